// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a non-pipelined 32-bit processor that runs a subset of a common load/store instruction set. Each instruction is fetched, decoded, executed, and retired within one clock period, and the next one starts only after that. The core contains a program counter, a 32-entry register file, an ALU with its own operation decoder, a small data RAM and a small built-in program ROM. It also holds the immediate extender, the branch and jump target adders, and the datapath multiplexers.

The program counter advances on the falling clock edge. The data RAM latches a load on the rising edge in the middle of the cycle. Stores and register writes take effect on the falling edge that ends the cycle. Holding the active-low reset loads the program counter from `start_pc`, so one ROM image can hold several entry points. The only visible output is the last word read from the data RAM. A program therefore shows its results by storing a value and reading it back.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the program counter is asynchronously loaded from `start_pc` and `dmem_rdata_o` is 0. After release, execution begins at `start_pc`.
- R2: Each instruction takes exactly one clock period. For an instruction that is not a taken branch or a jump, the program counter grows by 4 at the falling edge that ends the cycle.
- R3: The 16-bit immediate (bits 15:0) is sign-extended for addi, slti, lw, sw and beq, and zero-extended for andi, ori and xori.
- R4: Opcode 0x00 (register form) writes rs op rt to rd. rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11. The function code (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2a signed set-less-than.
- R5: Immediate forms write rs op imm to rt. The opcodes (bits 31:26) are 0x08 add, 0x0a signed set-less-than, 0x0c and, 0x0d or, 0x0e xor.
- R6: Register 0 always reads as zero, and writes to it have no effect.
- R7: sw (0x2b) writes rt to data word address rs+imm at the falling edge. lw (0x23) reads that word at the rising edge of its cycle, drives it on `dmem_rdata_o`, and writes it into rt at the falling edge.
- R8: `dmem_rdata_o` changes only at the rising edge of a cycle that executes lw. Otherwise it holds its value.
- R9: beq (0x04) compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. When they differ, the next PC is PC+4.
- R10: j (0x02) sets the next PC to the top 4 bits of PC+4, followed by the 26-bit index (bits 25:0), followed by two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The PC, register file and RAM writes act on the falling edge. RAM reads act on the rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| start_pc | input | 32 | Byte address loaded into the program counter during reset. |
| dmem_rdata_o | output | 32 | Word captured by the most recent load. |

## Verification
The hardest situation to reach from the ports is a taken beq closing a loop whose back edge is a jump. This case checks the branch target adder, the jump target and the branch priority together, and none of them is visible directly. The bench reaches it by holding reset with `start_pc` pointing into a ROM routine. That routine counts a register down to zero and accumulates the sum, then stores the sum and reloads it. The reloaded value shows whether the loop ran the correct number of times. Register contents are hidden, so every arithmetic result is brought out the same way: a store to a unique RAM word, followed by a load. Each load is sampled in the exact cycle it executes.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int XLEN   = 32;
   localparam int RIDX_W = 5;
   localparam int IMM_W  = 16;
   localparam int JIDX_W = 26;

   // primary opcodes, instruction bits 31:26
   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_J    = 6'h02;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_ADDI = 6'h08;
   localparam logic [5:0] OPC_SLTI = 6'h0a;
   localparam logic [5:0] OPC_ANDI = 6'h0c;
   localparam logic [5:0] OPC_ORI  = 6'h0d;
   localparam logic [5:0] OPC_XORI = 6'h0e;
   localparam logic [5:0] OPC_LW   = 6'h23;
   localparam logic [5:0] OPC_SW   = 6'h2b;

   // register-form function codes, instruction bits 5:0
   localparam logic [5:0] FC_ADD = 6'h20;
   localparam logic [5:0] FC_SUB = 6'h22;
   localparam logic [5:0] FC_AND = 6'h24;
   localparam logic [5:0] FC_OR  = 6'h25;
   localparam logic [5:0] FC_XOR = 6'h26;
   localparam logic [5:0] FC_NOR = 6'h27;
   localparam logic [5:0] FC_SLT = 6'h2a;

   // operation class requested by the main decoder
   typedef enum logic [2:0] {
      ACLS_ADD, ACLS_SUB, ACLS_FUNCT, ACLS_AND, ACLS_OR, ACLS_XOR, ACLS_SLT
   } alu_cls_e;

   // operation executed by the ALU
   typedef enum logic [2:0] {
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOR, FN_SLT
   } alu_fn_e;

   typedef struct packed {
      logic     dst_rd;     // destination is rd rather than rt
      logic     src_imm;    // ALU operand b comes from the immediate
      logic     wb_mem;     // write-back takes RAM data
      logic     rf_we;
      logic     mem_rd;
      logic     mem_wr;
      logic     is_branch;
      logic     is_jump;
      logic     imm_signed; // sign- rather than zero-extend
      alu_cls_e alu_cls;
   } ctrl_t;

   function automatic logic [XLEN-1:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                             input logic [4:0] rd, input logic [5:0] fc);
      return {OPC_REG, rs, rt, rd, 5'd0, fc};
   endfunction

   function automatic logic [XLEN-1:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                             input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [XLEN-1:0] enc_j(input logic [25:0] idx);
      return {OPC_J, idx};
   endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctl
);

   always_comb begin
      ctl         = '0;
      ctl.alu_cls = ACLS_ADD;
      case (opcode)
         OPC_REG: begin
            ctl.dst_rd  = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.alu_cls = ACLS_FUNCT;
         end
         OPC_ADDI: begin
            ctl.src_imm    = 1'b1;
            ctl.rf_we      = 1'b1;
            ctl.imm_signed = 1'b1;
         end
         OPC_SLTI: begin
            ctl.src_imm    = 1'b1;
            ctl.rf_we      = 1'b1;
            ctl.imm_signed = 1'b1;
            ctl.alu_cls    = ACLS_SLT;
         end
         OPC_ANDI: begin
            ctl.src_imm = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.alu_cls = ACLS_AND;
         end
         OPC_ORI: begin
            ctl.src_imm = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.alu_cls = ACLS_OR;
         end
         OPC_XORI: begin
            ctl.src_imm = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.alu_cls = ACLS_XOR;
         end
         OPC_LW: begin
            ctl.src_imm    = 1'b1;
            ctl.wb_mem     = 1'b1;
            ctl.rf_we      = 1'b1;
            ctl.mem_rd     = 1'b1;
            ctl.imm_signed = 1'b1;
         end
         OPC_SW: begin
            ctl.src_imm    = 1'b1;
            ctl.mem_wr     = 1'b1;
            ctl.imm_signed = 1'b1;
         end
         OPC_BEQ: begin
            ctl.is_branch  = 1'b1;
            ctl.imm_signed = 1'b1;
            ctl.alu_cls    = ACLS_SUB;
         end
         OPC_J: begin
            ctl.is_jump = 1'b1;
         end
         default: ctl.alu_cls = ACLS_ADD; // unknown opcode retires as a no-op
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu_ctl
   import sc_pkg::*;
(
   input  alu_cls_e   cls,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);

   always_comb begin
      case (cls)
         ACLS_SUB: fn = FN_SUB;
         ACLS_AND: fn = FN_AND;
         ACLS_OR:  fn = FN_OR;
         ACLS_XOR: fn = FN_XOR;
         ACLS_SLT: fn = FN_SLT;
         ACLS_FUNCT: begin
            case (funct)
               FC_SUB:  fn = FN_SUB;
               FC_AND:  fn = FN_AND;
               FC_OR:   fn = FN_OR;
               FC_XOR:  fn = FN_XOR;
               FC_NOR:  fn = FN_NOR;
               FC_SLT:  fn = FN_SLT;
               default: fn = FN_ADD;
            endcase
         end
         default: fn = FN_ADD;
      endcase
   end

endmodule

module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y,
   output logic         zero
);

   logic lt_s;
   assign lt_s = $signed(a) < $signed(b);

   always_comb begin
      case (fn)
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_XOR:  y = a ^ b;
         FN_NOR:  y = ~(a | b);
         FN_SLT:  y = {{(W-1){1'b0}}, lt_s};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W  = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);

   localparam int N = 1 << AW;

   if (AW < 1) begin : g_bad_aw
      $error("sc_regfile: AW must be at least 1");
   end

   logic [W-1:0] bank [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_flop
         logic [W-1:0] q;
         always_ff @(negedge clk) begin
            if (we && (wa == AW'(i))) q <= wd;
         end
         assign bank[i] = q;
      end
   end

   assign rd1 = bank[ra1];
   assign rd2 = bank[ra2];

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
   parameter int W  = 32,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("sc_dmem: AW out of supported range");
   end

   logic [W-1:0] mem [DEPTH];

   // store commits at the edge that ends the cycle
   always_ff @(negedge clk) begin
      if (wr_en) mem[waddr] <= wdata;
   end

   // load is captured mid-cycle, after address has settled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[waddr];
   end

endmodule

// File: rtl/sc_irom.sv
module sc_irom
   import sc_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic [AW-1:0]   waddr,
   output logic [XLEN-1:0] word
);

   localparam int DEPTH     = 1 << AW;
   localparam int PROG_LEN  = 52;
   localparam int DUMP_BASE = 14;
   localparam int DUMP_CNT  = 13;

   if (DEPTH < PROG_LEN) begin : g_bad_aw
      $error("sc_irom: AW too small for the built-in program");
   end

   // Pair k of the dump area stores one result register to byte 4k and
   // reloads it; the source order is r2..r7, r0, r9..r14.
   function automatic logic [XLEN-1:0] dump_word(input int unsigned i);
      int unsigned k;
      logic [4:0]  src;
      k   = (i - DUMP_BASE) / 2;
      src = (k == 6) ? 5'd0 : 5'(k + 2);
      if (((i - DUMP_BASE) % 2) == 0) return enc_i(OPC_SW, 5'd0, src, 16'(k * 4));
      else                            return enc_i(OPC_LW, 5'd0, 5'd15, 16'(k * 4));
   endfunction

   function automatic logic [XLEN-1:0] prog_word(input int unsigned i);
      case (i)
         // arithmetic and logic section
         0:  return enc_i(OPC_ADDI, 5'd0, 5'd1, 16'd7);
         1:  return enc_i(OPC_ADDI, 5'd0, 5'd2, 16'hFFFD);
         2:  return enc_i(OPC_ORI,  5'd0, 5'd3, 16'h8001);
         3:  return enc_i(OPC_ANDI, 5'd2, 5'd4, 16'hF0F0);
         4:  return enc_r(5'd1, 5'd2, 5'd5,  FC_ADD);
         5:  return enc_r(5'd1, 5'd2, 5'd6,  FC_SUB);
         6:  return enc_r(5'd2, 5'd1, 5'd7,  FC_SLT);
         7:  return enc_i(OPC_ADDI, 5'd0, 5'd0, 16'd55);
         8:  return enc_r(5'd3, 5'd4, 5'd9,  FC_OR);
         9:  return enc_r(5'd1, 5'd0, 5'd11, FC_NOR);
         10: return enc_r(5'd1, 5'd3, 5'd12, FC_XOR);
         11: return enc_i(OPC_SLTI, 5'd2, 5'd13, 16'hFFFE);
         12: return enc_i(OPC_XORI, 5'd1, 5'd14, 16'hFFFF);
         13: return enc_r(5'd2, 5'd3, 5'd10, FC_AND);
         // countdown loop section
         40: return enc_i(OPC_ADDI, 5'd0, 5'd1, 16'd3);
         41: return enc_i(OPC_ADDI, 5'd0, 5'd2, 16'd0);
         42: return enc_r(5'd2, 5'd1, 5'd2, FC_ADD);
         43: return enc_i(OPC_ADDI, 5'd1, 5'd1, 16'hFFFF);
         44: return enc_i(OPC_BEQ,  5'd1, 5'd0, 16'd1);
         45: return enc_j(26'd42);
         46: return enc_i(OPC_SW,   5'd0, 5'd2, 16'd8);
         47: return enc_i(OPC_LW,   5'd0, 5'd3, 16'd8);
         48: return enc_i(OPC_ADDI, 5'd0, 5'd4, 16'd20);
         49: return enc_i(OPC_SW,   5'd4, 5'd4, 16'hFFFC);
         50: return enc_i(OPC_LW,   5'd0, 5'd5, 16'd16);
         51: return enc_i(OPC_BEQ,  5'd0, 5'd0, 16'hFFFF);
         default: begin
            if (i >= DUMP_BASE && i < DUMP_BASE + 2 * DUMP_CNT) return dump_word(i);
            else return '0;
         end
      endcase
   endfunction

   assign word = prog_word(32'(waddr));

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int ROM_AW  = 6,
   parameter int DMEM_AW = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] start_pc,
   output logic [31:0] dmem_rdata_o
);

   localparam int PC_STEP = XLEN / 8;
   localparam int EXT_W   = XLEN - IMM_W;

   if (ROM_AW < 6 || ROM_AW > 16) begin : g_bad_rom
      $error("sc_core: ROM_AW out of supported range");
   end
   if (DMEM_AW < 4 || DMEM_AW > 12) begin : g_bad_dmem
      $error("sc_core: DMEM_AW out of supported range");
   end

   logic [XLEN-1:0]   pc_q, pc_plus4, pc_next;
   logic [XLEN-1:0]   instr;
   ctrl_t             ctl;
   alu_fn_e           fn;
   logic [XLEN-1:0]   rs_data, rt_data;
   logic [XLEN-1:0]   imm_ext, br_off, br_target, jmp_target;
   logic [XLEN-1:0]   alu_b, alu_y, wb_data;
   logic              alu_zero, br_taken;
   logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
   logic              unused_shamt;

   assign rs_idx       = instr[25:21];
   assign rt_idx       = instr[20:16];
   assign rd_idx       = instr[15:11];
   assign unused_shamt = ^instr[10:6];

   // program counter, the only storage outside the register file and RAM
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= start_pc;
      else        pc_q <= pc_next;
   end

   sc_irom #(.AW(ROM_AW)) u_irom (
      .waddr (pc_q[ROM_AW+1:2]),
      .word  (instr)
   );

   sc_ctrl u_ctrl (
      .opcode (instr[31:26]),
      .ctl    (ctl)
   );

   assign wb_idx = ctl.dst_rd ? rd_idx : rt_idx;

   sc_regfile #(.W(XLEN), .AW(RIDX_W)) u_rf (
      .clk (clk),
      .we  (ctl.rf_we & rst_n),
      .wa  (wb_idx),
      .wd  (wb_data),
      .ra1 (rs_idx),
      .ra2 (rt_idx),
      .rd1 (rs_data),
      .rd2 (rt_data)
   );

   assign imm_ext = ctl.imm_signed ? {{EXT_W{instr[15]}}, instr[15:0]}
                                   : {{EXT_W{1'b0}}, instr[15:0]};
   assign alu_b   = ctl.src_imm ? imm_ext : rt_data;

   sc_alu_ctl u_alu_ctl (
      .cls   (ctl.alu_cls),
      .funct (instr[5:0]),
      .fn    (fn)
   );

   sc_alu #(.W(XLEN)) u_alu (
      .a    (rs_data),
      .b    (alu_b),
      .fn   (fn),
      .y    (alu_y),
      .zero (alu_zero)
   );

   sc_dmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (ctl.mem_rd & rst_n),
      .wr_en (ctl.mem_wr & rst_n),
      .waddr (alu_y[DMEM_AW+1:2]),
      .wdata (rt_data),
      .rdata (dmem_rdata_o)
   );

   assign wb_data = ctl.wb_mem ? dmem_rdata_o : alu_y;

   // next-address generation: jump, then taken branch, then sequential
   assign pc_plus4   = pc_q + XLEN'(PC_STEP);
   assign br_off     = {{(EXT_W-2){instr[15]}}, instr[15:0], 2'b00};
   assign br_target  = pc_plus4 + br_off;
   assign jmp_target = {pc_plus4[31:28], instr[JIDX_W-1:0], 2'b00};
   assign br_taken   = ctl.is_branch & alu_zero;

   always_comb begin
      if (ctl.is_jump)   pc_next = jmp_target;
      else if (br_taken) pc_next = br_target;
      else               pc_next = pc_plus4;
   end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] start_pc,
   input logic [31:0] pc_q,
   input logic [31:0] instr,
   input logic [31:0] rs_data,
   input logic [31:0] rt_data,
   input logic        is_jump,
   input logic        is_branch,
   input logic        mem_rd,
   input logic [31:0] rdata
);

   logic [31:0] seq_exp, br_exp, j_exp;
   logic        eq_ops;

   assign seq_exp = pc_q + 32'd4;
   assign br_exp  = seq_exp + {{14{instr[15]}}, instr[15:0], 2'b00};
   assign j_exp   = {seq_exp[31:28], instr[25:0], 2'b00};
   assign eq_ops  = (rs_data == rt_data);

   // R1
   reset_pc_chk: assert property (@(posedge clk) !rst_n |-> (pc_q == start_pc));

   // R2
   seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !is_jump && !(is_branch && eq_ops)) |=> (pc_q == $past(seq_exp)));

   // R9
   beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !is_jump && is_branch && eq_ops) |=> (pc_q == $past(br_exp)));

   // R10
   jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && is_jump) |=> (pc_q == $past(j_exp)));

   // R6
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[25:21] == 5'd0) |-> (rs_data == 32'd0));

   // R8
   rdata_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !mem_rd |-> $stable(rdata));

endmodule

bind sc_core sc_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_pc  (start_pc),
   .pc_q      (pc_q),
   .instr     (instr),
   .rs_data   (rs_data),
   .rt_data   (rt_data),
   .is_jump   (ctl.is_jump),
   .is_branch (ctl.is_branch),
   .mem_rd    (ctl.mem_rd),
   .rdata     (dmem_rdata_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [31:0] start_pc = '0;
   logic [31:0] dmem_rdata_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc_seen = 0;
   bit done = 1'b0;

   sc_core dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_pc     (start_pc),
      .dmem_rdata_o (dmem_rdata_o)
   );

   always #10 clk = ~clk; // 50 MHz

   task automatic check(input string tag, input logic [31:0] exp);
      n_chk++;
      if (dmem_rdata_o !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, dmem_rdata_o, exp);
      end
   endtask

   // hold reset two falling edges, check the cleared output, release mid-low phase
   task automatic apply_reset(input logic [31:0] s);
      start_pc = s;
      rst_n    = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1 check("R1 reset clears load output", 32'd0);
      #2 rst_n = 1'b1;
      cyc_seen = 0;
   endtask

   // cycle k (0-based, counted from release) ends its load at posedge k+1
   task automatic at_cycle(input int k);
      while (cyc_seen < k + 1) begin
         @(posedge clk);
         cyc_seen++;
      end
      #5;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 4000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [31:0] a, b, ori_v, exp_a [13];
      string       tag_a [13];
      int          acc;

      a     = 32'd7;
      b     = 32'(-3);
      ori_v = {16'h0000, 16'h8001};
      exp_a[0]  = b;                                   tag_a[0]  = "R3 addi sign-extends";
      exp_a[1]  = ori_v;                               tag_a[1]  = "R3 ori zero-extends";
      exp_a[2]  = b & 32'h0000F0F0;                    tag_a[2]  = "R5 andi";
      exp_a[3]  = a + b;                               tag_a[3]  = "R4 add";
      exp_a[4]  = a - b;                               tag_a[4]  = "R4 sub";
      exp_a[5]  = ($signed(b) < $signed(a)) ? 1 : 0;   tag_a[5]  = "R4 slt signed";
      exp_a[6]  = 32'd0;                               tag_a[6]  = "R6 write to r0 ignored";
      exp_a[7]  = ori_v | exp_a[2];                    tag_a[7]  = "R4 or";
      exp_a[8]  = b & ori_v;                           tag_a[8]  = "R4 and";
      exp_a[9]  = ~(a | 32'd0);                        tag_a[9]  = "R4 nor";
      exp_a[10] = a ^ ori_v;                           tag_a[10] = "R4 xor";
      exp_a[11] = ($signed(b) < -2) ? 1 : 0;           tag_a[11] = "R5 slti signed";
      exp_a[12] = a ^ 32'h0000FFFF;                    tag_a[12] = "R3 xori zero-extends";

      #1;
      // arithmetic section, entry at byte 0
      apply_reset(32'd0);
      at_cycle(14);
      check("R2 no load before cycle 15", 32'd0);
      for (int i = 0; i < 13; i++) begin
         at_cycle(15 + 2 * i);
         check(tag_a[i], exp_a[i]);
         if (i < 12) begin
            at_cycle(16 + 2 * i);
            check("R8 output held during store", exp_a[i]);
         end
      end

      // loop section, entry at word 40 through start_pc
      apply_reset(32'd160);
      acc = 0;
      for (int c = 3; c > 0; c--) acc += c;
      at_cycle(13);
      check("R1 start_pc entry, no load yet", 32'd0);
      at_cycle(14);
      check("R9 R10 loop sum via beq/j", 32'(acc));
      at_cycle(16);
      check("R8 held after store", 32'(acc));
      at_cycle(17);
      check("R7 R3 store with negative offset reloaded", 32'd20);
      at_cycle(40);
      check("R9 self-branch halt keeps output", 32'd20);

      finish_run();
   end

endmodule